// File: doc/BRIEF.md
# Programmable Synchronous Serial Frame Transmitter

This block turns parallel words into a serial bit stream, one bit per cycle of its bit clock. The frame layout is set at run time. Each frame begins with a start event, which comes from an external trigger or from an internal period counter. The start event is followed by an idle gap of programmable length. After the gap comes an optional sync field, taken from a separate sync-word input. Then a programmable number of data words of programmable length are sent back to back, in either bit order. A frame-sync strobe marks the head of every frame. Outside the sync and data fields the data line rests at a configurable level.

Data words enter through a valid/ready stream interface. The block raises `word_ready` for exactly one cycle before each data word's first bit, and it does this whether or not a word is on offer. A word is taken when `word_ready` and `word_valid` are both high at a clock edge. The transmitter cannot wait for the source, because the serial line never stalls. If `word_valid` is low when `word_ready` is high, that word's slot goes out at the idle level and an underrun strobe is raised. A source may hold `word_valid` high with the next word ready at all times.

Configuration inputs are sampled continuously. They are expected to be held stable from the start event until the frame ends.

Top module: `frame_tx`

## Requirements
- R1: While reset is asserted and right after it, `sd_o` equals `cfg_idle_level`, and `fs_o`, `word_ready` and `underrun_o` are 0.
- R2: With `cfg_period` = 0, a frame starts at a clock edge where `start_i` is high and the block is idle. A `start_i` pulse during a frame is ignored and does not change that frame.
- R3: After the start edge, the line holds `cfg_idle_level` for `cfg_start_dly` cycles (0 to 255) before the sync or data field begins.
- R4: When `cfg_sync_en` = 1 and `cfg_sync_len` > 0, the sync field sends the low `cfg_sync_len` bits (up to 16) of `sync_word` right after the delay, in the selected bit order. Otherwise the field is skipped.
- R5: The data field sends `cfg_word_cnt_m1`+1 words (1 to 16), each `cfg_word_len_m1`+1 bits long (1 to 32), with no gaps. The line then returns to idle.
- R6: With `cfg_msb_first` = 1, bit (length−1) of each word or sync field goes out first and bit 0 last. With `cfg_msb_first` = 0, bit 0 goes out first.
- R7: `word_ready` is high in exactly one cycle per data word: the cycle just before that word's first bit. It does not depend on `word_valid`. The word present at that edge is the one sent.
- R8: If `word_valid` is low while `word_ready` is high, that word's bits are all `cfg_idle_level`. In that case `underrun_o` is high for the word's first bit cycle only.
- R9: `fs_o` is high for max(`cfg_sync_len`, 1) cycles, starting in the first cycle after the start edge, whatever the value of `cfg_sync_en`.
- R10: With `cfg_period` = P > 0 (P up to 512), start events are made internally every P cycles, the first in the cycle where P becomes non-zero. `start_i` is then ignored, and events that fall within a running frame are dropped.
- R11: Outside the sync and data fields, `sd_o` equals `cfg_idle_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | External start trigger (used when `cfg_period` = 0) |
| cfg_word_len_m1 | input | 5 | Data word length minus one |
| cfg_word_cnt_m1 | input | 4 | Words per frame minus one |
| cfg_sync_len | input | 5 | Sync field and frame-sync length, 0 to 16 |
| cfg_sync_en | input | 1 | Send the sync word on the data line |
| cfg_start_dly | input | 8 | Cycles between start event and first field |
| cfg_period | input | 10 | Internal frame period; 0 selects the external trigger |
| cfg_msb_first | input | 1 | 1: most significant bit first |
| cfg_idle_level | input | 1 | Data line level outside transfers |
| sync_word | input | 16 | Sync pattern, low bits used |
| word_data | input | 32 | Data word, low bits used |
| word_valid | input | 1 | Word stream valid |
| word_ready | output | 1 | Word stream ready (one cycle per word slot) |
| sd_o | output | 1 | Serial data |
| fs_o | output | 1 | Frame-sync strobe |
| underrun_o | output | 1 | Word slot found no valid word |

## Verification
The assertions take for granted that the configuration stays unchanged from a start event to the end of its frame. They also assume `cfg_sync_len` never exceeds 16 and that the period only changes while its counter is reloading. The stimulus meets these assumptions by changing configuration only between frames, after a few idle cycles have been observed. Random values are drawn within each field's legal range. Underruns are produced by withholding `word_valid` for chosen word slots, so the line level during a missed slot and the strobe timing are checked against the expected sequence for that frame.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DELAY,
    ST_SYNC,
    ST_DATA
  } ftx_state_e;
endpackage

// File: rtl/ftx_trigger.sv
module ftx_trigger #(
  parameter int PER_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [PER_W-1:0] period_i,
  output logic             evt_o
);
  logic [PER_W-1:0] pcnt;

  assign evt_o = (period_i == '0) ? start_i : (pcnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                pcnt <= '0;
    else if (period_i == '0)   pcnt <= '0;
    else if (pcnt == '0)       pcnt <= period_i - 1'b1;
    else                       pcnt <= pcnt - 1'b1;
  end

  // R10
  period_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && period_i > 1) |=> (!evt_o || !$stable(period_i)));
endmodule

// File: rtl/ftx_sequencer.sv
module ftx_sequencer
  import frame_tx_pkg::*;
#(
  parameter int LEN_W = 5,
  parameter int NW_W  = 4,
  parameter int SL_W  = 5,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt_i,
  input  logic [LEN_W-1:0] word_len_m1_i,
  input  logic [NW_W-1:0]  word_cnt_m1_i,
  input  logic [SL_W-1:0]  sync_len_i,
  input  logic             sync_en_i,
  input  logic [DLY_W-1:0] start_dly_i,
  output logic             start_acc_o,
  output logic             ld_sync_o,
  output logic             ld_word_o,
  output logic             active_o
);
  localparam int CNT_W = (DLY_W > LEN_W) ? ((DLY_W > SL_W) ? DLY_W : SL_W)
                                         : ((LEN_W > SL_W) ? LEN_W : SL_W);

  ftx_state_e       state, nxt;
  logic [CNT_W-1:0] bit_cnt, cnt_n;
  logic [NW_W-1:0]  word_left, wl_n;
  logic go_first, go_after_dly, go_data_first, go_next_word, go_word;
  logic sync_on;

  assign sync_on  = sync_en_i && (sync_len_i != '0);
  assign active_o = (state == ST_SYNC) || (state == ST_DATA);

  always_comb begin
    nxt = state;
    cnt_n = bit_cnt;
    wl_n = word_left;
    go_first = 1'b0;
    go_after_dly = 1'b0;
    go_data_first = 1'b0;
    go_next_word = 1'b0;
    go_word = 1'b0;
    ld_sync_o = 1'b0;
    case (state)
      ST_IDLE:  if (start_evt_i) go_first = 1'b1;
      ST_DELAY: if (bit_cnt == '0) go_after_dly = 1'b1;
                else cnt_n = bit_cnt - 1'b1;
      ST_SYNC:  if (bit_cnt == '0) go_data_first = 1'b1;
                else cnt_n = bit_cnt - 1'b1;
      ST_DATA:  if (bit_cnt == '0) begin
                  if (word_left == '0) nxt = ST_IDLE;
                  else go_next_word = 1'b1;
                end else cnt_n = bit_cnt - 1'b1;
      default:  nxt = ST_IDLE;
    endcase
    if (go_first) begin
      if (start_dly_i != '0) begin
        nxt = ST_DELAY;
        cnt_n = CNT_W'(start_dly_i - 1'b1);
      end else go_after_dly = 1'b1;
    end
    if (go_after_dly) begin
      if (sync_on) begin
        nxt = ST_SYNC;
        cnt_n = CNT_W'(sync_len_i - 1'b1);
        ld_sync_o = 1'b1;
      end else go_data_first = 1'b1;
    end
    if (go_data_first) begin
      wl_n = word_cnt_m1_i;
      go_word = 1'b1;
    end
    if (go_next_word) begin
      wl_n = word_left - 1'b1;
      go_word = 1'b1;
    end
    if (go_word) begin
      nxt = ST_DATA;
      cnt_n = CNT_W'(word_len_m1_i);
    end
    ld_word_o   = go_word;
    start_acc_o = go_first;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      word_left <= '0;
    end else begin
      state     <= nxt;
      bit_cnt   <= cnt_n;
      word_left <= wl_n;
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !start_evt_i) |=> (state == ST_IDLE));
  // R5
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && bit_cnt == '0 && word_left == '0) |=> (state == ST_IDLE));
endmodule

// File: rtl/ftx_shifter.sv
module ftx_shifter #(
  parameter int DATA_W = 32,
  parameter int SYNC_W = 16,
  parameter int LEN_W  = 5,
  parameter int SL_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_sync_i,
  input  logic              ld_word_i,
  input  logic              active_i,
  input  logic              word_valid_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [SYNC_W-1:0] sync_i,
  input  logic [LEN_W-1:0]  word_len_m1_i,
  input  logic [SL_W-1:0]   sync_len_i,
  input  logic              msb_first_i,
  input  logic              idle_i,
  output logic              sd_o,
  output logic              underrun_o
);
  logic [DATA_W-1:0] shreg, ld_val;
  logic [LEN_W:0]    ld_len, shamt;
  logic              ur_q;

  always_comb begin
    if (ld_sync_i) begin
      ld_val = DATA_W'(sync_i);
      ld_len = (LEN_W+1)'(sync_len_i);
    end else begin
      ld_val = word_i;
      ld_len = {1'b0, word_len_m1_i} + 1'b1;
    end
    shamt = (LEN_W+1)'(DATA_W) - ld_len;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      ur_q  <= 1'b0;
    end else begin
      ur_q <= ld_word_i && !word_valid_i;
      if (ld_word_i && !word_valid_i) shreg <= {DATA_W{idle_i}};
      else if (ld_sync_i || ld_word_i)
        shreg <= msb_first_i ? (ld_val << shamt) : ld_val;
      else if (active_i)
        shreg <= msb_first_i ? (shreg << 1) : (shreg >> 1);
    end
  end

  assign sd_o       = active_i ? (msb_first_i ? shreg[DATA_W-1] : shreg[0]) : idle_i;
  assign underrun_o = ur_q;
endmodule

// File: rtl/ftx_fsync.sv
module ftx_fsync #(
  parameter int SL_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_acc_i,
  input  logic [SL_W-1:0] sync_len_i,
  output logic            fs_o
);
  logic [SL_W-1:0] fs_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              fs_cnt <= '0;
    else if (start_acc_i)    fs_cnt <= (sync_len_i == '0) ? SL_W'(1) : sync_len_i;
    else if (fs_cnt != '0)   fs_cnt <= fs_cnt - 1'b1;
  end

  assign fs_o = (fs_cnt != '0);

  // R9
  fs_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc_i |=> fs_o);
endmodule

// File: rtl/frame_tx.sv
module frame_tx #(
  parameter int MAX_WORD_LEN = 32,
  parameter int MAX_WORDS    = 16,
  parameter int MAX_SYNC     = 16,
  parameter int DLY_W        = 8,
  parameter int PER_W        = 10,
  localparam int LEN_W = $clog2(MAX_WORD_LEN),
  localparam int NW_W  = $clog2(MAX_WORDS),
  localparam int SL_W  = $clog2(MAX_SYNC + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [LEN_W-1:0]        cfg_word_len_m1,
  input  logic [NW_W-1:0]         cfg_word_cnt_m1,
  input  logic [SL_W-1:0]         cfg_sync_len,
  input  logic                    cfg_sync_en,
  input  logic [DLY_W-1:0]        cfg_start_dly,
  input  logic [PER_W-1:0]        cfg_period,
  input  logic                    cfg_msb_first,
  input  logic                    cfg_idle_level,
  input  logic [MAX_SYNC-1:0]     sync_word,
  input  logic [MAX_WORD_LEN-1:0] word_data,
  input  logic                    word_valid,
  output logic                    word_ready,
  output logic                    sd_o,
  output logic                    fs_o,
  output logic                    underrun_o
);
  logic start_evt, start_acc, ld_sync, ld_word, active;

  ftx_trigger #(.PER_W(PER_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .period_i(cfg_period), .evt_o(start_evt)
  );

  ftx_sequencer #(.LEN_W(LEN_W), .NW_W(NW_W), .SL_W(SL_W), .DLY_W(DLY_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_evt_i(start_evt),
    .word_len_m1_i(cfg_word_len_m1), .word_cnt_m1_i(cfg_word_cnt_m1),
    .sync_len_i(cfg_sync_len), .sync_en_i(cfg_sync_en), .start_dly_i(cfg_start_dly),
    .start_acc_o(start_acc), .ld_sync_o(ld_sync), .ld_word_o(ld_word), .active_o(active)
  );

  ftx_shifter #(.DATA_W(MAX_WORD_LEN), .SYNC_W(MAX_SYNC), .LEN_W(LEN_W), .SL_W(SL_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .ld_sync_i(ld_sync), .ld_word_i(ld_word),
    .active_i(active), .word_valid_i(word_valid), .word_i(word_data),
    .sync_i(sync_word), .word_len_m1_i(cfg_word_len_m1), .sync_len_i(cfg_sync_len),
    .msb_first_i(cfg_msb_first), .idle_i(cfg_idle_level),
    .sd_o(sd_o), .underrun_o(underrun_o)
  );

  ftx_fsync #(.SL_W(SL_W)) u_fs (
    .clk(clk), .rst_n(rst_n), .start_acc_i(start_acc),
    .sync_len_i(cfg_sync_len), .fs_o(fs_o)
  );

  assign word_ready = ld_word;

  // R8
  underrun_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |-> (sd_o == cfg_idle_level));
  // R7
  take_no_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ready && word_valid) |=> !underrun_o);
endmodule

// File: tb/tb_frame_tx.sv
module tb_frame_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  len_m1 = '0;
  logic [3:0]  cnt_m1 = '0;
  logic [4:0]  sl = '0;
  logic        sync_en = 1'b0;
  logic [7:0]  dly = '0;
  logic [9:0]  period = '0;
  logic        msb = 1'b1;
  logic        idle = 1'b1;
  logic [15:0] sync_w = '0;
  logic [31:0] wdata = '0;
  logic        wvalid = 1'b0;
  logic        wready, sd, fs, ur;

  logic [31:0] words [16];
  logic [15:0] miss;
  logic        exp_sd [1024];
  logic        exp_fs [1024];
  logic        exp_ur [1024];
  int          exp_tag [1024];
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  frame_tx dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .cfg_word_len_m1(len_m1), .cfg_word_cnt_m1(cnt_m1), .cfg_sync_len(sl),
    .cfg_sync_en(sync_en), .cfg_start_dly(dly), .cfg_period(period),
    .cfg_msb_first(msb), .cfg_idle_level(idle), .sync_word(sync_w),
    .word_data(wdata), .word_valid(wvalid), .word_ready(wready),
    .sd_o(sd), .fs_o(fs), .underrun_o(ur)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tag_str(input int t);
    case (t)
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R11";
    endcase
  endfunction

  // Builds the expected line, strobe and underrun sequence for one frame.
  function automatic int build_frame();
    int idx = 0;
    int wl = int'(len_m1) + 1;
    int fl = (sl == 0) ? 1 : int'(sl);
    for (int i = 0; i < 1024; i++) begin
      exp_sd[i] = idle; exp_ur[i] = 1'b0; exp_tag[i] = 11;
      exp_fs[i] = (i < fl);
    end
    for (int i = 0; i < int'(dly); i++) begin exp_tag[idx] = 3; idx++; end
    if (sync_en && sl != 0)
      for (int b = 0; b < int'(sl); b++) begin
        exp_sd[idx] = msb ? sync_w[int'(sl) - 1 - b] : sync_w[b];
        exp_tag[idx] = 4; idx++;
      end
    for (int k = 0; k <= int'(cnt_m1); k++)
      for (int b = 0; b < wl; b++) begin
        if (miss[k]) begin
          exp_sd[idx] = idle; exp_ur[idx] = (b == 0); exp_tag[idx] = 5;
        end else begin
          exp_sd[idx] = msb ? words[k][wl - 1 - b] : words[k][b];
          exp_tag[idx] = msb ? 5 : 6;
        end
        idx++;
      end
    return idx;
  endfunction

  task automatic drive_word(input int ptr, input int n);
    if (ptr < n) begin
      wvalid = !miss[ptr];
      wdata  = words[ptr];
    end else begin
      wvalid = 1'b0;
      wdata  = '0;
    end
  endtask

  task automatic run_frame(input bit pulse_busy);
    int total, ptr, n;
    total = build_frame();
    n = int'(cnt_m1) + 1;
    ptr = 0;
    @(negedge clk);
    start_i = 1'b1;
    drive_word(ptr, n);
    #1;
    if (wready) ptr++;
    for (int c = 0; c < total + 3; c++) begin
      @(negedge clk);
      if (ur !== exp_ur[c])      chk(0, "R8", int'(ur), int'(exp_ur[c]));
      else if (fs !== exp_fs[c]) chk(0, "R9", int'(fs), int'(exp_fs[c]));
      else if (sd !== exp_sd[c]) chk(0, tag_str(exp_tag[c]), int'(sd), int'(exp_sd[c]));
      else chk(1, "R5", 0, 0);
      start_i = pulse_busy && (c == 3) && (total > 8); // R2 ignored mid-frame
      drive_word(ptr, n);
      #1;
      if (wready) ptr++;
    end
    chk(ptr == n, "R7 word slots", ptr, n);
    start_i = 1'b0;
    wvalid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_words();
    for (int k = 0; k < 16; k++) words[k] = $urandom;
    sync_w = 16'($urandom);
  endtask

  task automatic run_periodic(input int p);
    int rises[4];
    int nr = 0;
    logic prev = 1'b0;
    len_m1 = 5'd3; cnt_m1 = '0; sl = '0; sync_en = 1'b0; dly = 8'd2;
    wvalid = 1'b1; wdata = 32'h5; start_i = 1'b1; // start_i must be ignored
    @(negedge clk);
    period = 10'(p);
    for (int c = 0; c < 6 * p && nr < 4; c++) begin
      @(negedge clk);
      if (fs && !prev) begin rises[nr] = c; nr++; end
      prev = fs;
    end
    chk(nr == 4, "R10 frame count", nr, 4);
    for (int i = 1; i < nr; i++)
      chk(rises[i] - rises[i-1] == p, "R10 spacing", rises[i] - rises[i-1], p);
    period = '0; start_i = 1'b0; wvalid = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      done = 1;
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    miss = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sd == 1'b1 && fs == 1'b0 && wready == 1'b0 && ur == 1'b0, "R1 in reset",
        int'({sd, fs, wready, ur}), 8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sd == 1'b1 && fs == 1'b0 && wready == 1'b0 && ur == 1'b0, "R1 after reset",
        int'({sd, fs, wready, ur}), 8);

    // Directed: no delay, no sync, single 1-bit word
    set_words(); idle = 1'b0; msb = 1'b1; dly = '0; sl = '0; sync_en = 1'b1;
    len_m1 = '0; cnt_m1 = '0; run_frame(0);
    // Directed: full-width words, LSB first, max sync (R4, R6)
    set_words(); idle = 1'b1; msb = 1'b0; dly = 8'd5; sl = 5'd16; sync_en = 1'b1;
    len_m1 = 5'd31; cnt_m1 = 4'd3; run_frame(1);
    // Directed: 16 words, sync length set but sync disabled (R9 strobe still full)
    set_words(); msb = 1'b1; dly = 8'd1; sl = 5'd7; sync_en = 1'b0;
    len_m1 = 5'd7; cnt_m1 = 4'd15; run_frame(1);
    // Directed: max delay, underruns on first and last word (R3, R8)
    set_words(); idle = 1'b0; dly = 8'd255; sl = 5'd3; sync_en = 1'b1;
    len_m1 = 5'd4; cnt_m1 = 4'd4; miss = 16'h0011; run_frame(0);
    miss = '0;

    // Constrained random frames
    for (int f = 0; f < 40; f++) begin
      set_words();
      len_m1  = 5'($urandom % 32);
      cnt_m1  = 4'($urandom % 16);
      sl      = 5'($urandom % 17);
      sync_en = 1'($urandom);
      dly     = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 8);
      msb     = 1'($urandom);
      idle    = 1'($urandom);
      miss    = ($urandom % 3 == 0) ? 16'($urandom & $urandom) : 16'h0;
      run_frame(1'($urandom));
    end
    miss = '0;

    run_periodic(20);
    run_periodic(9);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule